// File: doc/BRIEF.md
# Voltage-Frequency Transition Sequencer

This block moves a core from one performance point to another. Software writes a requested core-to-bus ratio and a requested voltage ID (VID) code. The block then walks the VID code one step at a time and switches the ratio, in an order chosen so that the core never runs at a higher ratio than its present voltage can support. A larger VID code means a higher supply voltage, and each code is one 12.5 mV step. Only the core ratio output changes. The bus clock is not touched.

When the requested ratio is above the present one, the VID is raised to its target first and the ratio switches afterwards. When the requested ratio is lower, the ratio drops first and the VID moves afterwards. When the ratio is unchanged, only the VID is walked. Every VID step and every ratio switch is followed by a fixed dwell of `DWELL` settle ticks, which stands in for regulator settling and clock relock.

Requests arrive on a valid/ready write port. `wr_ready` is always high, so the block never applies back-pressure. A request written while a transition is running goes into a single pending slot, and a later write overwrites it. The pending request starts as soon as the running transition completes.

Top module: `vf_transition_seq`

## Requirements
- R1: After reset, `cur_vid` is `RST_VID` (40), `cur_ratio` is `RST_RATIO` (8), `busy` is 0 and `wr_ready` is 1.
- R2: When the clamped requested ratio is above the current ratio, the VID steps up to the clamped target before `cur_ratio` changes. At the moment of the ratio switch, `cur_vid` is at least the target.
- R3: When the clamped requested ratio is below the current ratio, `cur_ratio` changes before any change of `cur_vid`.
- R4: `cur_vid` changes by exactly one code per step. Between any two output changes (VID step or ratio switch) there are at least `DWELL` (3) settle ticks, so there are at least `DWELL`+1 cycles when the tick is held high. The two outputs never change in the same cycle.
- R5: The dwell only advances on cycles with `settle_tick` high. While the tick is held low after a step, both outputs hold and `busy` stays high.
- R6: The requested ratio is clamped to the `max_ratio` value sampled with the write.
- R7: The requested VID is clamped to the range [`VID_MIN`, `VID_MAX`] (16 to 96), and `cur_vid` never leaves that range.
- R8: When the clamped requested ratio equals the current ratio, `cur_ratio` stays the same and only the VID walks to the target.
- R9: A write accepted while `busy` is high is held and applied after the running transition ends. Only the most recent such write is kept, and an overwritten request is never applied.
- R10: `busy` rises in the cycle after a write is accepted while idle. It falls once both outputs equal the clamped target. While idle with no write, both outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Request write valid |
| wr_ready | output | 1 | Always 1, no back-pressure |
| wr_ratio | input | RATIO_W | Requested core-to-bus ratio |
| wr_vid | input | VID_W | Requested VID code |
| max_ratio | input | RATIO_W | Highest allowed ratio, sampled with the write |
| settle_tick | input | 1 | Settle timer tick that advances the dwell |
| cur_vid | output | VID_W | Current VID code driven to the regulator |
| cur_ratio | output | RATIO_W | Current core ratio |
| busy | output | 1 | A transition is in progress |

## Verification
The sequencer is tested with four kinds of move: an upward ratio move with a higher VID, a downward ratio move with a lower VID, and equal-ratio moves that walk the VID in either direction. These separate the raise-then-switch order from the switch-then-walk order, and show whether an equal ratio is wrongly treated as a switch. Out-of-range requests for both ratio and VID show whether the clamps work. A walk with the tick held low shows whether the dwell is gated by the tick. A run of back-to-back writes during a transition shows whether the pending slot keeps only the last request, and whether that request starts after the first transition ends.

// File: rtl/vfs_pkg.sv
package vfs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RAISE,
    ST_SWITCH,
    ST_WALK,
    ST_DWELL
  } vfs_state_e;
endpackage

// File: rtl/vfs_req_clamp.sv
module vfs_req_clamp #(
  parameter int RATIO_W = 6,
  parameter int VID_W   = 7,
  parameter int VID_MIN = 16,
  parameter int VID_MAX = 96
) (
  input  logic [RATIO_W-1:0] req_ratio,
  input  logic [VID_W-1:0]   req_vid,
  input  logic [RATIO_W-1:0] lim_ratio,
  output logic [RATIO_W-1:0] ok_ratio,
  output logic [VID_W-1:0]   ok_vid
);
  localparam logic [VID_W-1:0] VLO = VID_W'(VID_MIN);
  localparam logic [VID_W-1:0] VHI = VID_W'(VID_MAX);

  always_comb begin
    ok_ratio = (req_ratio > lim_ratio) ? lim_ratio : req_ratio;
    if (req_vid < VLO)      ok_vid = VLO;
    else if (req_vid > VHI) ok_vid = VHI;
    else                    ok_vid = req_vid;
  end
endmodule

// File: rtl/vfs_pend_slot.sv
module vfs_pend_slot #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         take,
  output logic         held,
  output logic [W-1:0] held_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held      <= 1'b0;
      held_data <= '0;
    end else if (load) begin
      held      <= 1'b1;
      held_data <= load_data;
    end else if (take) begin
      held      <= 1'b0;
    end
  end
endmodule

// File: rtl/vfs_dwell_cnt.sv
module vfs_dwell_cnt #(
  parameter int DWELL = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic adv,
  output logic expire
);
  localparam int CW = (DWELL < 2) ? 1 : $clog2(DWELL + 1);
  localparam logic [CW-1:0] LAST = CW'(DWELL - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt <= '0;
    else if (adv)        cnt <= cnt + 1'b1;
  end

  assign expire = adv && (cnt == LAST);
endmodule

// File: rtl/vf_transition_seq.sv
module vf_transition_seq #(
  parameter int RATIO_W   = 6,
  parameter int VID_W     = 7,
  parameter int VID_MIN   = 16,
  parameter int VID_MAX   = 96,
  parameter int RST_VID   = 40,
  parameter int RST_RATIO = 8,
  parameter int DWELL     = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [RATIO_W-1:0] wr_ratio,
  input  logic [VID_W-1:0]   wr_vid,
  input  logic [RATIO_W-1:0] max_ratio,
  input  logic               settle_tick,
  output logic [VID_W-1:0]   cur_vid,
  output logic [RATIO_W-1:0] cur_ratio,
  output logic               busy
);
  import vfs_pkg::*;

  localparam int PW = RATIO_W + VID_W;

  vfs_state_e        state, ret_state;
  logic [RATIO_W-1:0] tgt_ratio, cl_ratio, nxt_ratio;
  logic [VID_W-1:0]   tgt_vid, cl_vid, nxt_vid;
  logic               pend_v, pend_load, finishing, idle, have_req, dwell_done;
  logic [PW-1:0]      pend_d;

  vfs_req_clamp #(
    .RATIO_W(RATIO_W), .VID_W(VID_W), .VID_MIN(VID_MIN), .VID_MAX(VID_MAX)
  ) u_clamp (
    .req_ratio(wr_ratio), .req_vid(wr_vid), .lim_ratio(max_ratio),
    .ok_ratio(cl_ratio), .ok_vid(cl_vid)
  );

  assign idle      = (state == ST_IDLE);
  assign finishing = (state == ST_WALK) && (cur_vid == tgt_vid);
  assign pend_load = wr_valid && !(idle || finishing);
  assign have_req  = wr_valid || pend_v;

  vfs_pend_slot #(.W(PW)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .load(pend_load), .load_data({cl_ratio, cl_vid}),
    .take(finishing), .held(pend_v), .held_data(pend_d)
  );

  // A fresh write beats the pending slot: it is the most recent request.
  always_comb begin
    if (wr_valid) begin
      nxt_ratio = cl_ratio;
      nxt_vid   = cl_vid;
    end else begin
      nxt_ratio = pend_d[PW-1:VID_W];
      nxt_vid   = pend_d[VID_W-1:0];
    end
  end

  vfs_dwell_cnt #(.DWELL(DWELL)) u_dwell (
    .clk(clk), .rst_n(rst_n),
    .clear(state != ST_DWELL),
    .adv((state == ST_DWELL) && settle_tick),
    .expire(dwell_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ret_state <= ST_IDLE;
      cur_vid   <= VID_W'(RST_VID);
      cur_ratio <= RATIO_W'(RST_RATIO);
      tgt_vid   <= VID_W'(RST_VID);
      tgt_ratio <= RATIO_W'(RST_RATIO);
    end else begin
      case (state)
        ST_IDLE: begin
          if (have_req) begin
            tgt_ratio <= nxt_ratio;
            tgt_vid   <= nxt_vid;
            state     <= (nxt_ratio > cur_ratio) ? ST_RAISE : ST_SWITCH;
          end
        end
        ST_RAISE: begin
          if (cur_vid < tgt_vid) begin
            cur_vid   <= cur_vid + 1'b1;
            ret_state <= ST_RAISE;
            state     <= ST_DWELL;
          end else begin
            state <= ST_SWITCH;
          end
        end
        ST_SWITCH: begin
          if (cur_ratio != tgt_ratio) begin
            cur_ratio <= tgt_ratio;
            ret_state <= ST_WALK;
            state     <= ST_DWELL;
          end else begin
            state <= ST_WALK;
          end
        end
        ST_WALK: begin
          if (cur_vid < tgt_vid) begin
            cur_vid   <= cur_vid + 1'b1;
            ret_state <= ST_WALK;
            state     <= ST_DWELL;
          end else if (cur_vid > tgt_vid) begin
            cur_vid   <= cur_vid - 1'b1;
            ret_state <= ST_WALK;
            state     <= ST_DWELL;
          end else if (have_req) begin
            tgt_ratio <= nxt_ratio;
            tgt_vid   <= nxt_vid;
            state     <= (nxt_ratio > cur_ratio) ? ST_RAISE : ST_SWITCH;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_DWELL: begin
          if (dwell_done) state <= ret_state;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = !idle;
  assign wr_ready = 1'b1;
endmodule

// File: rtl/vfs_chk.sv
module vfs_chk #(
  parameter int RATIO_W = 6,
  parameter int VID_W   = 7,
  parameter int VID_MIN = 16,
  parameter int VID_MAX = 96
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_valid,
  input logic               busy,
  input logic [VID_W-1:0]   cur_vid,
  input logic [RATIO_W-1:0] cur_ratio,
  input logic [VID_W-1:0]   tgt_vid
);
  // R4
  vid_unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_vid) |-> (cur_vid == $past(cur_vid) + 1'b1) || (cur_vid == $past(cur_vid) - 1'b1));

  // R4
  move_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cur_vid) || !$stable(cur_ratio)) |=> ($stable(cur_vid) && $stable(cur_ratio)));

  // R4
  single_output_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_vid) |-> $stable(cur_ratio));

  // R7
  vid_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_vid >= VID_W'(VID_MIN)) && (cur_vid <= VID_W'(VID_MAX)));

  // R2
  raise_before_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_ratio > $past(cur_ratio)) |-> (cur_vid >= tgt_vid));

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_valid) |=> busy);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_valid) |=> ($stable(cur_vid) && $stable(cur_ratio)));
endmodule

bind vf_transition_seq vfs_chk #(
  .RATIO_W(RATIO_W), .VID_W(VID_W), .VID_MIN(VID_MIN), .VID_MAX(VID_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .busy(busy),
  .cur_vid(cur_vid), .cur_ratio(cur_ratio), .tgt_vid(tgt_vid)
);

// File: tb/sim_vf_transition_seq.sv
module sim_vf_transition_seq;
  localparam int CLK_P = 10;
  localparam int DWELL = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [5:0] wr_ratio = '0;
  logic [6:0] wr_vid = '0;
  logic [5:0] max_ratio = 6'd20;
  logic       settle_tick = 1'b1;
  logic [6:0] cur_vid;
  logic [5:0] cur_ratio;
  logic       busy;

  int checks = 0;
  int failures = 0;

  // trace kept by the monitor
  int cyc = 0;
  int last_move = -100;
  int min_gap = 1000;
  int bad_delta = 0;
  int vid_steps = 0;
  int first_vid_cyc = -1;
  int last_vid_cyc = -1;
  int ratio_cyc = -1;
  int vid_at_ratio = -1;
  int ratio_moves = 0;
  bit seen10 = 0;
  bit seen18 = 0;
  logic [6:0] pv;
  logic [5:0] pr;

  always #(CLK_P/2) clk = ~clk;

  vf_transition_seq #(.DWELL(DWELL)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_ratio(wr_ratio), .wr_vid(wr_vid), .max_ratio(max_ratio),
    .settle_tick(settle_tick), .cur_vid(cur_vid), .cur_ratio(cur_ratio), .busy(busy)
  );

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (cur_vid != pv) begin
        if (!((cur_vid == pv + 7'd1) || (cur_vid == pv - 7'd1))) bad_delta = bad_delta + 1;
        vid_steps = vid_steps + 1;
        if (first_vid_cyc < 0) first_vid_cyc = cyc;
        last_vid_cyc = cyc;
      end
      if (cur_ratio != pr) begin
        ratio_moves = ratio_moves + 1;
        if (ratio_cyc < 0) begin
          ratio_cyc = cyc;
          vid_at_ratio = int'(cur_vid);
        end
      end
      if (cur_vid != pv || cur_ratio != pr) begin
        if (cyc - last_move < min_gap) min_gap = cyc - last_move;
        last_move = cyc;
      end
      if (cur_ratio == 6'd10) seen10 = 1;
      if (cur_ratio == 6'd18) seen18 = 1;
    end
    pv = cur_vid;
    pr = cur_ratio;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_trace();
    last_move = -100; min_gap = 1000; bad_delta = 0; vid_steps = 0;
    first_vid_cyc = -1; last_vid_cyc = -1; ratio_cyc = -1; vid_at_ratio = -1;
    ratio_moves = 0; seen10 = 0; seen18 = 0;
  endtask

  task automatic put(input int r, input int v, input int m);
    @(negedge clk);
    wr_valid = 1'b1; wr_ratio = 6'(r); wr_vid = 7'(v); max_ratio = 6'(m);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      if (!busy) return;
      @(negedge clk);
    end
    check(0, "R10 busy never fell", 1, 0);
  endtask

  task automatic t_reset();
    check(cur_vid == 7'd40, "R1 reset vid", cur_vid, 40);
    check(cur_ratio == 6'd8, "R1 reset ratio", cur_ratio, 8);
    check(busy == 1'b0, "R1 reset busy", busy, 0);
    check(wr_ready == 1'b1, "R1 ready", wr_ready, 1);
  endtask

  task automatic t_up();
    clear_trace();
    put(12, 44, 20);
    check(busy == 1'b1, "R10 busy after write", busy, 1);
    wait_idle();
    check(cur_ratio == 6'd12 && cur_vid == 7'd44, "R10 up final", cur_vid, 44);
    check(vid_at_ratio == 44, "R2 vid at ratio switch", vid_at_ratio, 44);
    check(ratio_cyc > last_vid_cyc, "R2 ratio after last vid step", ratio_cyc, last_vid_cyc);
    check(vid_steps == 4 && bad_delta == 0, "R4 unit steps up", vid_steps, 4);
    check(min_gap >= DWELL + 1, "R4 dwell gap", min_gap, DWELL + 1);
  endtask

  task automatic t_down();
    clear_trace();
    put(6, 38, 20);
    wait_idle();
    check(cur_ratio == 6'd6 && cur_vid == 7'd38, "R3 down final", cur_vid, 38);
    check(ratio_cyc > 0 && ratio_cyc < first_vid_cyc, "R3 ratio before vid", ratio_cyc, first_vid_cyc);
    check(vid_steps == 6 && bad_delta == 0, "R4 unit steps down", vid_steps, 6);
  endtask

  task automatic t_equal();
    clear_trace();
    put(6, 41, 20);
    wait_idle();
    check(ratio_moves == 0, "R8 ratio untouched", ratio_moves, 0);
    check(cur_vid == 7'd41 && vid_steps == 3, "R8 vid walked", cur_vid, 41);
  endtask

  task automatic t_clamps();
    clear_trace();
    put(30, 41, 14);
    wait_idle();
    check(cur_ratio == 6'd14, "R6 ratio clamped", cur_ratio, 14);
    put(14, 120, 20);
    wait_idle();
    check(cur_vid == 7'd96, "R7 vid clamp high", cur_vid, 96);
    put(14, 3, 20);
    wait_idle();
    check(cur_vid == 7'd16, "R7 vid clamp low", cur_vid, 16);
  endtask

  task automatic t_tick_gate();
    settle_tick = 1'b0;
    put(14, 20, 20);
    repeat (20) @(negedge clk);
    check(cur_vid == 7'd17, "R5 held after one step", cur_vid, 17);
    check(busy == 1'b1, "R5 busy while gated", busy, 1);
    settle_tick = 1'b1;
    wait_idle();
    check(cur_vid == 7'd20, "R5 resumes with tick", cur_vid, 20);
  endtask

  task automatic t_pending();
    clear_trace();
    put(10, 30, 20);
    put(18, 25, 20);
    put(16, 24, 20);
    check(busy == 1'b1, "R9 still busy", busy, 1);
    wait_idle();
    check(seen10 == 1'b1, "R9 first target applied", seen10, 1);
    check(seen18 == 1'b0, "R9 overwritten request dropped", seen18, 0);
    check(cur_ratio == 6'd16 && cur_vid == 7'd24, "R9 last request final", cur_vid, 24);
  endtask

  initial begin
    #(CLK_P * 150000);
    check(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_up();
    t_down();
    t_equal();
    t_clamps();
    t_tick_gate();
    t_pending();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule